// File: doc/BRIEF.md
# Two-Wire Converter Command Slave

This block is the serial front end of an eight-channel 12-bit data converter. It sits on a two-wire bus with clock and data lines that have already been synchronised to the system clock, and it takes part in the bus only by enabling an open-drain pull-down on the data line. It detects bus start and stop conditions and recognises its own 7-bit address. On a write it acknowledges the address and one control byte, and decodes that byte into a channel number, a range bit, a polarity bit and a power-down code. On a read it shifts out the latest conversion result.

The converter core uses two timing pulses from this block. The first pulse comes as soon as the polarity bit of the control byte has been sampled, so that input acquisition can begin before the byte has finished. The second pulse marks the stop condition that closes such a write, and it ends acquisition. The master's acknowledge bits during a read are never interpreted. After two data bytes the block leaves the line released, so any further clocks read back as ones.

Top module: `twowire_conv_slave`

## Requirements
- R1: After reset, `sda_pull`, `acq_start` and `acq_end` are 0, and `chan_sel`, `range_hi`, `bipolar_en` and `pd_mode` are all 0.
- R2: The first byte after a START is sampled on SCL rising edges, MSB first. Its upper seven bits are compared with binary 0101 followed by `addr_sel[2:0]`, and bit 0 is read/write (0 = write, 1 = read). On a match, `sda_pull` is 1 from one clock after the eighth SCL falling edge until one clock after the ninth.
- R3: On an address mismatch, `sda_pull` stays 0, no pulse is issued and no field changes until the next START.
- R4: After a write acknowledge, 0 bits are skipped. The first 1 bit sampled opens the control byte, and the block acknowledges that 8-bit byte in the same way as in R2.
- R5: The control byte is, from MSB to LSB: opening 1, channel[2:0], range, polarity, power-down[1:0]. `chan_sel`, `range_hi` and `bipolar_en` take their new values one clock after the SCL rise that samples the polarity bit. `pd_mode` takes its new value one clock after the rise that samples the last bit.
- R6: `acq_start` is a one-clock pulse one clock after the SCL rise that samples the polarity bit.
- R7: The first STOP after an `acq_start` gives a one-clock `acq_end` pulse one clock after the STOP is seen. A repeated START between the two does not cancel it.
- R8: On a read match, the result is sent as bits 11..4, then bits 3..0 followed by four zeros, MSB first. Each bit is put on the line one clock after the SCL falling edge that ends the previous slot, and `sda_pull` is 1 for a 0 bit.
- R9: During the ninth clock of each data byte, `sda_pull` is 0 and the master's ACK or NACK has no effect on the bits that follow.
- R10: Once both data bytes and their acknowledge slots are done, `sda_pull` stays 0 for any further clocks.
- R11: A START at any point abandons the current byte and restarts address reception.
- R12: One clock after a STOP is seen, `sda_pull` is 0.
- R13: `sda_pull` only rises while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised serial clock sample |
| sda_i | input | 1 | Synchronised serial data sample (wired line level) |
| addr_sel | input | 3 | Low three bits of the slave address |
| conv_data | input | 12 | Latest conversion result, captured at the start of a read |
| sda_pull | output | 1 | 1 enables the open-drain pull-down on the data line |
| chan_sel | output | 3 | Selected input channel |
| range_hi | output | 1 | Range select bit |
| bipolar_en | output | 1 | Polarity select bit |
| pd_mode | output | 2 | Power-down code |
| acq_start | output | 1 | Pulse: begin input acquisition |
| acq_end | output | 1 | Pulse: end acquisition |

## Verification
A bit counter that is off by one shows on the very next acknowledge: the pull-down appears one SCL period early or late, which is at most about twenty system clocks after the fault. A wrong protocol state or a lost address decision shows as a pull-down where none belongs, or as a missing acknowledge on the following byte. A misaligned read shift register corrupts the first data bit driven after the address acknowledge, and a wrongly kept acquisition flag shows as a missing or extra `acq_end` at the next stop. The reference model therefore compares every output on every system clock, so that each of these faults is reported within one SCL period.

// File: rtl/tws_pkg.sv
package tws_pkg;
  // Protocol state of the slave
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD_WAIT,
    ST_CMD,
    ST_CMD_ACK,
    ST_READ,
    ST_SKIP
  } tws_state_e;
endpackage

// File: rtl/tws_bus_cond.sv
// Edge and bus-condition detector for synchronised SCL/SDA samples
module tws_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/tws_ctrl_decode.sv
// Control-field registers, loaded in two steps as the control byte arrives
module tws_ctrl_decode #(
  parameter int CH_W = 3,
  parameter int PD_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_sel,
  input  logic            load_pd,
  input  logic [CH_W+1:0] frag,
  output logic [CH_W-1:0] chan_sel,
  output logic            range_hi,
  output logic            bipolar_en,
  output logic [PD_W-1:0] pd_mode
);
  logic [CH_W-1:0] chan_d;
  logic            rng_d, bip_d;
  logic [PD_W-1:0] pd_d;

  always_comb begin
    chan_d = chan_sel;
    rng_d  = range_hi;
    bip_d  = bipolar_en;
    pd_d   = pd_mode;
    if (load_sel) begin
      chan_d = frag[CH_W+1:2];
      rng_d  = frag[1];
      bip_d  = frag[0];
    end
    if (load_pd) begin
      pd_d = frag[PD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_sel   <= '0;
      range_hi   <= 1'b0;
      bipolar_en <= 1'b0;
      pd_mode    <= '0;
    end else begin
      chan_sel   <= chan_d;
      range_hi   <= rng_d;
      bipolar_en <= bip_d;
      pd_mode    <= pd_d;
    end
  end
endmodule

// File: rtl/tws_read_shift.sv
// Read-data serialiser: NBYTES bytes, each followed by an ignored master ack slot
module tws_read_shift #(
  parameter int RES_W  = 12,
  parameter int NBYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             adv,
  input  logic [RES_W-1:0] res,
  output logic             pull
);
  localparam int DATA_W = NBYTES * 8;
  localparam int PAD_W  = DATA_W - RES_W;
  localparam int NB_W   = $clog2(NBYTES + 1);
  localparam logic [NB_W-1:0] NB_END   = NB_W'(NBYTES);
  localparam logic [3:0]      ACK_SLOT = 4'd8;

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [3:0]        slot_q, slot_d;
  logic [NB_W-1:0]   nb_q, nb_d;
  logic              act_q, act_d, pull_d;

  always_comb begin
    sh_d   = sh_q;
    slot_d = slot_q;
    nb_d   = nb_q;
    act_d  = act_q;
    pull_d = pull;
    if (clr) begin
      act_d  = 1'b0;
      pull_d = 1'b0;
    end else if (load) begin
      sh_d   = {res, {PAD_W{1'b0}}};
      slot_d = '0;
      nb_d   = '0;
      act_d  = 1'b1;
      pull_d = ~res[RES_W-1];
    end else if (adv && act_q) begin
      if (slot_q == ACK_SLOT) begin
        slot_d = '0;
        if (nb_q != NB_END) nb_d = nb_q + NB_W'(1);
        pull_d = (nb_d != NB_END) && !sh_q[DATA_W-1];
      end else begin
        sh_d   = sh_q << 1;
        slot_d = slot_q + 4'd1;
        pull_d = (slot_d != ACK_SLOT) && (nb_q != NB_END) && !sh_d[DATA_W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      slot_q <= '0;
      nb_q   <= '0;
      act_q  <= 1'b0;
      pull   <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      slot_q <= slot_d;
      nb_q   <= nb_d;
      act_q  <= act_d;
      pull   <= pull_d;
    end
  end
endmodule

// File: rtl/twowire_conv_slave.sv
// Two-wire bus slave that takes converter commands and returns results
module twowire_conv_slave #(
  parameter int               HI_W    = 4,
  parameter logic [HI_W-1:0]  ADDR_HI = 4'b0101,
  parameter int               SEL_W   = 3,
  parameter int               RES_W   = 12,
  parameter int               CH_W    = 3,
  parameter int               PD_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SEL_W-1:0] addr_sel,
  input  logic [RES_W-1:0] conv_data,
  output logic             sda_pull,
  output logic [CH_W-1:0]  chan_sel,
  output logic             range_hi,
  output logic             bipolar_en,
  output logic [PD_W-1:0]  pd_mode,
  output logic             acq_start,
  output logic             acq_end
);
  import tws_pkg::*;

  localparam logic [3:0] BYTE_END = 4'd8;
  localparam logic [3:0] SEL_AT   = 4'(CH_W + 2);  // count before the polarity bit
  localparam logic [3:0] PD_AT    = 4'd7;          // count before the last bit

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  logic scl_rise, scl_fall, start_det, stop_det;
  tws_bus_cond u_cond (
    .clk(clk), .rst_n(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tws_state_e state_q, state_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d, sh_in;
  logic       ack_q, ack_d, rnw_q, rnw_d, pend_q, pend_d;
  logic       start_d, end_d, load_sel, load_pd, rd_load, rd_adv, rd_clr, rd_pull;

  assign sh_in = {sh_q[6:0], sda_i};

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    ack_d    = ack_q;
    rnw_d    = rnw_q;
    pend_d   = pend_q;
    start_d  = 1'b0;
    end_d    = 1'b0;
    load_sel = 1'b0;
    load_pd  = 1'b0;
    rd_load  = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      ack_d   = 1'b0;
      if (pend_q) begin
        end_d  = 1'b1;
        pend_d = 1'b0;
      end
    end else if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      ack_d   = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR: begin
          if (scl_rise && cnt_q != BYTE_END) begin
            sh_d  = sh_in;
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == BYTE_END) begin
            if (sh_q[7:1] == {ADDR_HI, addr_sel}) begin
              state_d = ST_ADDR_ACK;
              ack_d   = 1'b1;
              rnw_d   = sh_q[0];
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            ack_d = 1'b0;
            if (rnw_q) begin
              state_d = ST_READ;
              rd_load = 1'b1;
            end else begin
              state_d = ST_CMD_WAIT;
            end
          end
        end
        ST_CMD_WAIT: begin
          if (scl_rise && sda_i) begin
            state_d = ST_CMD;
            sh_d    = sh_in;
            cnt_d   = 4'd1;
          end
        end
        ST_CMD: begin
          if (scl_rise && cnt_q != BYTE_END) begin
            sh_d  = sh_in;
            cnt_d = cnt_q + 4'd1;
            if (cnt_q == SEL_AT) begin
              load_sel = 1'b1;
              start_d  = 1'b1;
              pend_d   = 1'b1;
            end
            if (cnt_q == PD_AT) load_pd = 1'b1;
          end else if (scl_fall && cnt_q == BYTE_END) begin
            state_d = ST_CMD_ACK;
            ack_d   = 1'b1;
          end
        end
        ST_CMD_ACK: begin
          if (scl_fall) begin
            ack_d   = 1'b0;
            state_d = ST_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      ack_q     <= 1'b0;
      rnw_q     <= 1'b0;
      pend_q    <= 1'b0;
      acq_start <= 1'b0;
      acq_end   <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      ack_q     <= ack_d;
      rnw_q     <= rnw_d;
      pend_q    <= pend_d;
      acq_start <= start_d;
      acq_end   <= end_d;
    end
  end

  tws_ctrl_decode #(.CH_W(CH_W), .PD_W(PD_W)) u_dec (
    .clk(clk), .rst_n(rst_ni), .load_sel(load_sel), .load_pd(load_pd),
    .frag(sh_in[CH_W+1:0]), .chan_sel(chan_sel), .range_hi(range_hi),
    .bipolar_en(bipolar_en), .pd_mode(pd_mode)
  );

  assign rd_clr = start_det | stop_det;
  assign rd_adv = scl_fall && (state_q == ST_READ);

  tws_read_shift #(.RES_W(RES_W), .NBYTES(2)) u_rd (
    .clk(clk), .rst_n(rst_ni), .clr(rd_clr), .load(rd_load), .adv(rd_adv),
    .res(conv_data), .pull(rd_pull)
  );

  assign sda_pull = ack_q | rd_pull;
endmodule

// File: rtl/tws_checker.sv
// Temporal checks on the slave's ports
module tws_checker #(
  parameter int CH_W = 3,
  parameter int PD_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scl_i,
  input logic            sda_i,
  input logic            sda_pull,
  input logic            acq_start,
  input logic            acq_end,
  input logic [CH_W-1:0] chan_sel,
  input logic            range_hi,
  input logic            bipolar_en,
  input logic [PD_W-1:0] pd_mode
);
  logic scl_p, sda_p, pend, stop_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
      pend  <= 1'b0;
    end else begin
      scl_p <= scl_i;
      sda_p <= sda_i;
      if (acq_start)    pend <= 1'b1;
      else if (acq_end) pend <= 1'b0;
    end
  end

  assign stop_seen = scl_i & scl_p & ~sda_p & sda_i;

  // R12
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !sda_pull);

  // R13
  pull_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !$past(scl_i));

  // R6
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start |=> !acq_start);

  // R6
  start_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start |-> $past(scl_i));

  // R7
  end_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_end |-> pend);

  // R5
  sel_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({chan_sel, range_hi, bipolar_en}) |-> acq_start);

  // R5
  pd_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pd_mode) |-> $past(scl_i));
endmodule

bind twowire_conv_slave tws_checker #(.CH_W(CH_W), .PD_W(PD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_pull(sda_pull),
  .acq_start(acq_start), .acq_end(acq_end), .chan_sel(chan_sel),
  .range_hi(range_hi), .bipolar_en(bipolar_en), .pd_mode(pd_mode)
);

// File: tb/test_twowire_conv_slave.sv
`timescale 1ns/1ps
module test_twowire_conv_slave;
  localparam int HP = 6;  // system clocks per SCL phase

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_line;
  logic [2:0]  addr_sel = 3'b101;
  logic [11:0] conv_data = '0;
  logic        sda_pull, range_hi, bipolar_en, acq_start, acq_end;
  logic [2:0]  chan_sel;
  logic [1:0]  pd_mode;

  always #4 clk = ~clk;  // 125 MHz

  assign sda_line = m_sda & ~sda_pull;

  twowire_conv_slave i_twowire_conv_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_sel(addr_sel), .conv_data(conv_data), .sda_pull(sda_pull),
    .chan_sel(chan_sel), .range_hi(range_hi), .bipolar_en(bipolar_en),
    .pd_mode(pd_mode), .acq_start(acq_start), .acq_end(acq_end)
  );

  // reference model state
  int    checks = 0;
  int    failures = 0;
  bit    mon_en = 0;
  bit    done = 0;
  string cur_req = "R1";
  bit    exp_pull = 0, exp_start = 0, exp_end = 0, pend = 0;
  bit    exp_rng = 0, exp_bip = 0;
  bit [2:0] exp_chan = '0;
  bit [1:0] exp_pd = '0;
  bit [7:0] cur_ctrl = '0;
  bit    pull_prev = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (mon_en) begin
      chk(sda_pull === exp_pull, cur_req, "sda_pull", int'(sda_pull), int'(exp_pull));
      chk(acq_start === exp_start, "R6", "acq_start", int'(acq_start), int'(exp_start));
      chk(acq_end === exp_end, "R7", "acq_end", int'(acq_end), int'(exp_end));
      chk(chan_sel === exp_chan, "R5", "chan_sel", int'(chan_sel), int'(exp_chan));
      chk(range_hi === exp_rng, "R5", "range_hi", int'(range_hi), int'(exp_rng));
      chk(bipolar_en === exp_bip, "R5", "bipolar_en", int'(bipolar_en), int'(exp_bip));
      chk(pd_mode === exp_pd, "R5", "pd_mode", int'(pd_mode), int'(exp_pd));
      // R13: a new pull-down only while SCL is low
      if (sda_pull && !pull_prev) chk(scl == 1'b0, "R13", "scl at pull rise", int'(scl), 0);
      pull_prev = sda_pull;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one SCL clock; evt 1 = polarity bit sampled, 2 = last control bit sampled
  task automatic sclk(input bit b, input bit pull_after, input int evt);
    m_sda = b;
    tick(HP);
    scl = 1'b1;
    if (evt == 1) begin
      exp_start = 1;
      exp_chan  = cur_ctrl[6:4];
      exp_rng   = cur_ctrl[3];
      exp_bip   = cur_ctrl[2];
      pend      = 1;
    end else if (evt == 2) begin
      exp_pd = cur_ctrl[1:0];
    end
    tick(1);
    exp_start = 0;
    tick(HP - 1);
    scl = 1'b0;
    exp_pull = pull_after;
    tick(HP);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(HP);
    scl = 1'b1;   tick(HP);
    m_sda = 1'b0; tick(HP);
    scl = 1'b0;   tick(HP);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(HP);
    scl = 1'b1;   tick(HP);
    m_sda = 1'b1;
    if (pend) begin exp_end = 1; pend = 0; end
    tick(1);
    exp_end = 0;
    tick(HP);
    chk(sda_pull == 1'b0, "R12", "pull after stop", int'(sda_pull), 0);
  endtask

  task automatic send_addr(input bit [6:0] a, input bit rnw, input bit match);
    bit [7:0] b;
    b = {a, rnw};
    cur_req = match ? "R2" : "R3";
    for (int i = 0; i < 8; i++) sclk(b[7-i], (i == 7) && match, 0);
  endtask

  task automatic wr_tx(input bit [6:0] a, input bit [7:0] ctrl, input int nlead,
                       input bit match, input bit do_stop);
    bus_start();
    send_addr(a, 1'b0, match);
    sclk(1'b1, 1'b0, 0);
    cur_req = match ? "R4" : "R3";
    for (int i = 0; i < nlead; i++) sclk(1'b0, 1'b0, 0);
    cur_ctrl = ctrl;
    for (int i = 0; i < 8; i++)
      sclk(ctrl[7-i], (i == 7) && match, !match ? 0 : (i == 5) ? 1 : (i == 7) ? 2 : 0);
    sclk(1'b1, 1'b0, 0);
    if (do_stop) bus_stop();
  endtask

  function automatic bit drv(input bit [15:0] w, input int j);
    if (j < 8)  return ~w[15-j];
    if (j == 8) return 1'b0;
    if (j < 17) return ~w[16-j];
    return 1'b0;
  endfunction

  task automatic rd_tx(input bit [6:0] a, input bit match, input bit [11:0] d,
                       input int nclk, input bit mack);
    bit [15:0] w;
    conv_data = d;
    w = {d, 4'b0000};
    bus_start();
    send_addr(a, 1'b1, match);
    sclk(1'b1, match ? drv(w, 0) : 1'b0, 0);
    for (int i = 0; i < nclk; i++) begin
      cur_req = !match ? "R3" : (i == 8 || i == 17) ? "R9" : (i > 16) ? "R10" : "R8";
      sclk((i == 8) ? mack : 1'b1, match ? drv(w, i + 1) : 1'b0, 0);
    end
    bus_stop();
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(4);
    chk(sda_pull == 0, "R1", "sda_pull", int'(sda_pull), 0);
    chk(acq_start == 0 && acq_end == 0, "R1", "pulses", int'({acq_start, acq_end}), 0);
    chk(chan_sel == 0 && pd_mode == 0, "R1", "chan/pd", int'({chan_sel, pd_mode}), 0);
    chk(range_hi == 0 && bipolar_en == 0, "R1", "rng/bip", int'({range_hi, bipolar_en}), 0);
    mon_en = 1;

    // R2 R4 R5 R6 R7: write, no leading zeros
    wr_tx({4'b0101, 3'b101}, 8'b1_011_1_1_10, 0, 1, 1);
    // R4: leading zeros skipped before the opening 1
    wr_tx({4'b0101, 3'b101}, 8'b1_110_0_1_01, 3, 1, 1);
    // R3: mismatch in low bits, then in the fixed upper bits
    wr_tx({4'b0101, 3'b100}, 8'b1_001_1_0_11, 0, 0, 1);
    wr_tx({4'b0111, 3'b101}, 8'b1_001_1_0_11, 0, 0, 1);
    // R8 with master ACK
    rd_tx({4'b0101, 3'b101}, 1, 12'hA5C, 18, 1'b0);
    // R9 master NACK ignored, R10 extra clocks read released
    rd_tx({4'b0101, 3'b101}, 1, 12'h3F1, 22, 1'b1);
    // R8 all-ones and all-zeros results
    rd_tx({4'b0101, 3'b101}, 1, 12'hFFF, 18, 1'b0);
    rd_tx({4'b0101, 3'b101}, 1, 12'h000, 18, 1'b0);
    // R3 read mismatch
    rd_tx({4'b0101, 3'b001}, 0, 12'h123, 18, 1'b0);
    // R11: repeated START mid address byte, then a read
    bus_start();
    cur_req = "R11";
    for (int i = 0; i < 4; i++) sclk(1'b1, 1'b0, 0);
    rd_tx({4'b0101, 3'b101}, 1, 12'h800, 18, 1'b0);
    // R7 R11: write, repeated START into a read; acquisition ends at the read's STOP
    wr_tx({4'b0101, 3'b101}, 8'b1_100_1_0_00, 1, 1, 0);
    rd_tx({4'b0101, 3'b101}, 1, 12'h6B3, 18, 1'b0);
    // R2: new address-select value
    addr_sel = 3'b010;
    wr_tx({4'b0101, 3'b010}, 8'b1_111_0_0_11, 0, 1, 1);
    wr_tx({4'b0101, 3'b101}, 8'b1_000_1_1_00, 0, 0, 1);

    tick(10);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule